// File: doc/BRIEF.md
# Stream-to-Memory Receive Channel

This block drains a byte-wide AXI4-Stream into a memory buffer. Software programs a destination base address and then a maximum length through a small register port. Writing the length arms the channel. Each accepted byte goes out on a simple byte-write memory port at the base address plus a running offset.

A transfer ends when a beat carrying tlast is accepted. It does not end when the programmed length is reached. The number of bytes actually stored can then be read back from the length offset. A programmed length of zero is an error. So is a packet that brings more bytes than the programmed length before tlast. An error halts the channel until a soft reset, which also pulses an output that neighbouring blocks can use to flush their own state.

The register port writes on a single-cycle strobe. Reads are combinational from the same address bus.

Top module: `rx_stream_dma`

## Requirements
- R1: Accepting a beat (s_tvalid and s_tready both high) that has s_tlast high ends the transfer. s_tready is low from the next cycle on, even if fewer bytes than the programmed length arrived.
- R2: Reading offset 0x58 returns the number of bytes stored in the current or most recent transfer, not the programmed length.
- R3: A length write whose field reg_wdata[15:0] is zero, made while idle, sets the error flag and leaves the channel disarmed.
- R4: When a beat is accepted after exactly the programmed number of bytes has been stored, that beat is not written, the error flag is set and s_tready goes low. A packet whose tlast falls exactly on the last allowed byte completes without error.
- R5: The k-th byte of a transfer (k counted from 0) is written with mem_we high at mem_addr = base + k. The offset restarts at zero on every new transfer.
- R6: Status at offset 0x34 has bit 1 = idle (neither armed nor in error) and bit 4 = error flag. All other bits read as 0.
- R7: s_tready is high exactly while a transfer is armed. It is low when idle and low while the error flag is set.
- R8: A non-zero write to the length field at offset 0x58 arms the channel, with the byte count cleared, only when the channel is neither armed nor in error. Otherwise it is ignored. A write to the base address at offset 0x48 is ignored while armed.
- R9: Writing offset 0x30 with bit 2 set disarms the channel, clears the error flag and the byte count, and drives chan_rst_o high for the following cycle.
- R10: After rst_n the channel is idle with no error, s_tready low, chan_rst_o low and a byte count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| s_tdata | input | 8 | Stream byte |
| s_tvalid | input | 1 | Stream valid |
| s_tlast | input | 1 | Stream end of packet |
| s_tready | output | 1 | Stream ready, high while armed |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| chan_rst_o | output | 1 | One-cycle pulse after a soft reset |

## Verification
The hardest situations to reach from the ports are register writes that land while a transfer is still in flight: a second length write, or a new base address, arriving between beats. The stimulus stops the stream partway through an armed packet, issues both writes, and then resumes. The packet is long enough that an accepted shorter length would have forced an overrun, and an accepted new base would have moved the remaining bytes. The overrun itself is reached by arming a short length and streaming a longer packet. Soft-reset recovery is reached by trying to re-arm while the error flag is still set.

// File: rtl/rx_stream_dma.sv
module rx_stream_dma #(
  parameter int MEM_AW = 16,
  parameter int LEN_W  = 16,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [7:0]        s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              chan_rst_o
);
  localparam logic [7:0] OFS_CTL = 8'h30;
  localparam logic [7:0] OFS_STA = 8'h34;
  localparam logic [7:0] OFS_DST = 8'h48;
  localparam logic [7:0] OFS_LEN = 8'h58;
  localparam int SRST_BIT = 2;
  localparam int IDLE_BIT = 1;
  localparam int ERR_BIT  = 4;

  logic              armed, err, rst_p;
  logic [LEN_W-1:0]  cnt, max_len;
  logic [MEM_AW-1:0] base;

  wire beat   = s_tvalid && armed;
  wire full   = (cnt == max_len);
  wire srst   = reg_we && reg_addr == OFS_CTL && reg_wdata[SRST_BIT];
  wire wr_len = reg_we && reg_addr == OFS_LEN && !armed && !err;
  wire wr_dst = reg_we && reg_addr == OFS_DST && !armed;
  wire [LEN_W-1:0] len_f = reg_wdata[LEN_W-1:0];

  assign s_tready   = armed;
  assign mem_we     = beat && !full;
  assign mem_addr   = base + MEM_AW'(cnt);
  assign mem_wdata  = s_tdata;
  assign chan_rst_o = rst_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      err     <= 1'b0;
      rst_p   <= 1'b0;
      cnt     <= '0;
      max_len <= '0;
      base    <= '0;
    end else begin
      rst_p <= srst;
      if (beat) begin
        if (full) begin
          err   <= 1'b1;
          armed <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
          if (s_tlast) armed <= 1'b0;
        end
      end
      if (wr_dst) base <= reg_wdata[MEM_AW-1:0];
      if (wr_len) begin
        if (len_f == '0) err <= 1'b1;
        else begin
          max_len <= len_f;
          cnt     <= '0;
          armed   <= 1'b1;
        end
      end
      if (srst) begin
        armed <= 1'b0;
        err   <= 1'b0;
        cnt   <= '0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_STA: begin
        reg_rdata[IDLE_BIT] = !armed && !err;
        reg_rdata[ERR_BIT]  = err;
      end
      OFS_DST: reg_rdata = DW'(base);
      OFS_LEN: reg_rdata = DW'(cnt);
      default: reg_rdata = '0;
    endcase
  end

  AST_LAST_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast) |=> !s_tready); // R1
  AST_ZERO_LEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_len && len_f == '0) |=> (err && !s_tready)); // R3
  AST_OVERRUN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && full && !srst) |=> (err && !s_tready)); // R4
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !s_tready); // R7
  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_len && len_f != '0) |=> (s_tready && cnt == '0)); // R8
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst_o |-> (!s_tready && !err && cnt == '0)); // R9
endmodule

// File: tb/rx_stream_dma_test.sv
`timescale 1ns/1ps
module rx_stream_dma_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0]  s_tdata = 0;
  logic        s_tvalid = 0, s_tlast = 0, s_tready;
  logic        mem_we, chan_rst_o;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0, fails = 0;
  logic [7:0] ram [0:255];
  logic [7:0] exp_ram [0:255];
  int m_armed = 0, m_err = 0, m_cnt = 0, m_max = 0, m_dest = 0, m_rstp = 0;

  rx_stream_dma uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tlast(s_tlast), .s_tready(s_tready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .chan_rst_o(chan_rst_o));

  always #10 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_err = 0; m_cnt = 0; m_max = 0; m_dest = 0; m_rstp = 0;
    end else begin
      int was_armed, was_err;
      was_armed = m_armed; was_err = m_err;
      m_rstp = 0;
      if (was_armed != 0 && s_tvalid) begin
        if (m_cnt == m_max) begin m_err = 1; m_armed = 0; end
        else begin
          exp_ram[(m_dest + m_cnt) & 255] = s_tdata;
          m_cnt++;
          if (s_tlast) m_armed = 0;
        end
      end
      if (reg_we) begin
        if (reg_addr == 8'h48 && was_armed == 0) m_dest = int'(reg_wdata[15:0]);
        if (reg_addr == 8'h58 && was_armed == 0 && was_err == 0) begin
          if (reg_wdata[15:0] == 0) m_err = 1;
          else begin m_max = int'(reg_wdata[15:0]); m_cnt = 0; m_armed = 1; end
        end
        if (reg_addr == 8'h30 && reg_wdata[2]) begin
          m_armed = 0; m_err = 0; m_cnt = 0; m_rstp = 1;
        end
      end
    end
  end

  // every-cycle comparison against the model (R5, R7, R9)
  always @(negedge clk) if (rst_n) begin
    int we_exp;
    we_exp = (s_tvalid && m_armed != 0 && m_cnt != m_max) ? 1 : 0;
    check("R7 tready", int'(s_tready), m_armed);
    check("R5 mem_we", int'(mem_we), we_exp);
    check("R9 chan_rst_o", int'(chan_rst_o), m_rstp);
    if (we_exp != 0) begin
      check("R5 mem_addr", int'(mem_addr), (m_dest + m_cnt) & 16'hFFFF);
      check("R5 mem_wdata", int'(mem_wdata), int'(s_tdata));
    end
    if (mem_we) ram[mem_addr[7:0]] = mem_wdata;
  end

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    s_tvalid = 0; s_tlast = 0;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 0;
  endtask

  task automatic rchk(string tag, input logic [7:0] a, int exp);
    @(posedge clk); #2;
    reg_we = 0; s_tvalid = 0; s_tlast = 0; reg_addr = a;
    @(negedge clk);
    check(tag, int'(reg_rdata), exp);
  endtask

  task automatic send(int n, int first, int with_last, int gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps != 0 && i % 2 == 1) begin
        @(posedge clk); #2; s_tvalid = 0; s_tlast = 0;
      end
      @(posedge clk); #2;
      s_tvalid = 1; s_tdata = 8'(first + i);
      s_tlast = (with_last != 0 && i == n - 1);
    end
    @(posedge clk); #2; s_tvalid = 0; s_tlast = 0;
  endtask

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = 0; exp_ram[i] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check("R10 tready after reset", int'(s_tready), 0);
    check("R10 chan_rst_o after reset", int'(chan_rst_o), 0);
    rchk("R10 status after reset", 8'h34, 2);
    rchk("R10 count after reset", 8'h58, 0);

    wreg(8'h48, 16); wreg(8'h58, 8);
    send(5, 8'h10, 1, 0);
    rchk("R2 short packet count", 8'h58, 5);
    rchk("R1 idle after tlast", 8'h34, 2);
    check("R1 tready low after tlast", int'(s_tready), 0);

    wreg(8'h48, 40); wreg(8'h58, 4);
    send(4, 8'h30, 1, 0);
    rchk("R4 exact length no error", 8'h34, 2);
    rchk("R2 exact length count", 8'h58, 4);

    wreg(8'h48, 60); wreg(8'h58, 3);
    send(5, 8'h50, 1, 0);
    rchk("R4 overrun count", 8'h58, 3);
    rchk("R6 overrun status", 8'h34, 16);
    check("R7 tready low in error", int'(s_tready), 0);
    wreg(8'h58, 10);
    check("R8 length ignored in error", int'(s_tready), 0);
    rchk("R8 status still error", 8'h34, 16);

    wreg(8'h30, 4);
    @(negedge clk);
    check("R9 reset pulse", int'(chan_rst_o), 1);
    rchk("R9 status after soft reset", 8'h34, 2);
    rchk("R9 count after soft reset", 8'h58, 0);

    wreg(8'h58, 0);
    rchk("R3 zero length error", 8'h34, 16);
    check("R3 not armed", int'(s_tready), 0);
    wreg(8'h30, 4);

    wreg(8'h48, 100); wreg(8'h58, 10);
    send(2, 8'h70, 0, 0);
    wreg(8'h58, 2);
    wreg(8'h48, 200);
    rchk("R8 base kept while armed", 8'h48, 100);
    send(4, 8'h72, 1, 0);
    rchk("R8 length rewrite ignored", 8'h58, 6);
    rchk("R8 no error", 8'h34, 2);

    wreg(8'h48, 120); wreg(8'h58, 6);
    send(6, 8'h90, 1, 1);
    rchk("R2 gapped packet count", 8'h58, 6);
    rchk("R6 gapped status", 8'h34, 2);

    repeat (2) @(posedge clk);
    for (int i = 0; i < 256; i++) check("R5 memory contents", int'(ram[i]), int'(exp_ram[i]));
    check("R5 offset restart byte", int'(ram[120]), 8'h90);
    check("R5 first byte at base", int'(ram[16]), 8'h10);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule